// File: doc/BRIEF.md
# Multiply-Accumulate Unit with HI/LO Accumulator

This block is the multiply-accumulate engine of a 64-bit integer core. A 64-bit accumulator is formed from the low word of HI (the upper half of the accumulator) and the low word of LO (the lower half). A decoded instruction arrives as a 5-bit shift-amount field (`sa_code`) and a 6-bit function field (`fn_code`), together with two 64-bit source operands and a one-cycle `start` strobe. The unit multiplies the low words of the sources, signed or unsigned. It then loads, negates into, adds to or subtracts from the accumulator, optionally with saturation. It returns a value for the destination register.

The latency is fixed. `busy` is high while an operation is in flight. In the cycle that `done` pulses, HI, LO and the destination value all update together. A doubleword variant adds the product to the whole 64-bit LO and returns LO. Encodings that are not defined are reported through `bad_op` and leave HI/LO untouched.

Top module: `macc_hilo_unit`

## Requirements
- R1: After reset, `hi_out`, `lo_out` and `dest_out` are zero, and `busy`, `done` and `bad_op` are low.
- R2: A `start` sampled while idle raises `busy` at the next edge. `done` pulses for one cycle exactly LATENCY edges after that, with `busy` low. A `start` while `busy` is high is ignored and produces no second `done`.
- R3: The accumulator is {HI[31:0], LO[31:0]}. A non-doubleword operation writes result[63:32] into HI[31:0] and result[31:0] into LO[31:0], and keeps HI[63:32] and LO[63:32].
- R4: The product uses only bits [31:0] of each source. Signed variants sign-extend both words and unsigned variants zero-extend them. Bits [63:32] of the sources have no effect.
- R5: With `fn_code`=101000, `sa_code` 0010u/0110u load the accumulator with the product (u = `sa_code[0]`, 1 = unsigned). With `fn_code`=011000 (signed) or 011001 (unsigned), `sa_code` 00011/01011 load it with 0 minus the product.
- R6: With `fn_code`=101000, `sa_code` 0001u/0101u add the product to the accumulator. With `fn_code` 011000/011001, `sa_code` 01111 subtracts the product. `sa_code` 00111 subtracts the product only with 011001 (unsigned).
- R7: `sa_code[3]` picks the half returned: 1 returns accumulator bits [63:32] and 0 returns bits [31:0]. Either half is sign-extended to 64 bits in `dest_out`.
- R8: With `fn_code`=101001, `sa_code` 0000u and 1000u add the product to the whole 64-bit LO. HI is unchanged and `dest_out` equals the new LO.
- R9: Signed saturating accumulate applies to `fn_code`=101000 with `sa_code` 10000/11000, and to `fn_code`=101001 with `sa_code` 10000. The exact sum is clamped to the range -2^31 to 2^31-1 and sign-extended to 64 bits.
- R10: Unsigned saturating accumulate applies to `fn_code`=101000 with `sa_code` 10001/11001, and to `fn_code`=101001 with `sa_code` 10001. An exact sum above 0x7FFFFFFF becomes all ones.
- R11: Any other {`fn_code`,`sa_code`} pair still runs the full latency. `bad_op` pulses together with `done`, `dest_out` reads zero, and HI/LO are unchanged.
- R12: `hi_out` and `lo_out` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, taken when idle |
| sa_code | input | 5 | Variant field of the instruction |
| fn_code | input | 6 | Function field of the instruction |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| bad_op | output | 1 | Undefined encoding, with `done` |
| dest_out | output | 64 | Value for the destination register |
| hi_out | output | 64 | HI register |
| lo_out | output | 64 | LO register |

## Verification
Every result is due at one point: the edge LATENCY cycles after the edge that sampled `start`. At that edge `done`, `bad_op`, `dest_out`, HI and LO all change together. The bench drives on falling edges and counts falling edges until `done` is seen, which must be the (LATENCY+1)-th one. It compares all outputs there against an arithmetic model that tracks HI/LO. At every falling edge before that point, it confirms that HI and LO still hold their previous values.

// File: rtl/macc_pkg.sv
package macc_pkg;
  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;
  localparam int SA_W = 5;
  localparam int FN_W = 6;

  localparam logic [FN_W-1:0] FN_ACC   = 6'b101000;
  localparam logic [FN_W-1:0] FN_DACC  = 6'b101001;
  localparam logic [FN_W-1:0] FN_NEG_S = 6'b011000;
  localparam logic [FN_W-1:0] FN_NEG_U = 6'b011001;

  typedef enum logic [2:0] {
    OPK_CLEAR = 3'd0,
    OPK_NEG   = 3'd1,
    OPK_ADD   = 3'd2,
    OPK_SUB   = 3'd3,
    OPK_DADD  = 3'd4
  } opk_e;

  typedef struct packed {
    logic legal;
    opk_e kind;
    logic uns;
    logic sat;
    logic hi_sel;
  } mac_op_t;

  // Full-width product of two low words.
  function automatic logic [XLEN-1:0] mac_product(input logic [HALF-1:0] a,
                                                  input logic [HALF-1:0] b,
                                                  input logic uns);
    logic [XLEN-1:0] ea, eb;
    ea = uns ? {{HALF{1'b0}}, a} : {{HALF{a[HALF-1]}}, a};
    eb = uns ? {{HALF{1'b0}}, b} : {{HALF{b[HALF-1]}}, b};
    return ea * eb;
  endfunction

  // Exact sum (one guard bit) clamped to a signed half-word range.
  function automatic logic [XLEN-1:0] clamp_signed(input logic [XLEN:0] s);
    logic [XLEN-HALF+1:0] top;
    top = s[XLEN:HALF-1];
    if ((&top) || !(|top)) return s[XLEN-1:0];
    if (s[XLEN]) return {{(XLEN-HALF+1){1'b1}}, {(HALF-1){1'b0}}};
    return {{(XLEN-HALF+1){1'b0}}, {(HALF-1){1'b1}}};
  endfunction

  // Exact unsigned sum: anything above the largest positive half goes to all ones.
  function automatic logic [XLEN-1:0] clamp_unsigned(input logic [XLEN:0] s);
    if (|s[XLEN:HALF-1]) return {XLEN{1'b1}};
    return s[XLEN-1:0];
  endfunction

  function automatic logic [XLEN-1:0] sext_half(input logic [HALF-1:0] h);
    return {{HALF{h[HALF-1]}}, h};
  endfunction
endpackage

// File: rtl/macc_decode.sv
module macc_decode
  import macc_pkg::*;
(
  input  logic [SA_W-1:0] sa_code,
  input  logic [FN_W-1:0] fn_code,
  output mac_op_t         op
);
  always_comb begin
    op        = '0;
    op.kind   = OPK_CLEAR;
    op.hi_sel = sa_code[3];
    unique case (fn_code)
      FN_ACC: begin
        op.uns = sa_code[0];
        op.sat = sa_code[4];
        unique casez (sa_code)
          5'b0010?, 5'b0110?: begin op.legal = 1'b1; op.kind = OPK_CLEAR; end
          5'b0001?, 5'b0101?,
          5'b1000?, 5'b1100?: begin op.legal = 1'b1; op.kind = OPK_ADD; end
          default: op.legal = 1'b0;
        endcase
      end
      FN_DACC: begin
        op.uns    = sa_code[0];
        op.sat    = sa_code[4];
        op.hi_sel = 1'b0;
        op.kind   = OPK_DADD;
        op.legal  = (sa_code[3:1] == 3'b000);
      end
      FN_NEG_S, FN_NEG_U: begin
        op.uns = fn_code[0];
        unique case (sa_code)
          5'b00011, 5'b01011: begin op.legal = 1'b1; op.kind = OPK_NEG; end
          5'b01111:           begin op.legal = 1'b1; op.kind = OPK_SUB; end
          5'b00111:           begin op.legal = fn_code[0]; op.kind = OPK_SUB; end
          default: op.legal = 1'b0;
        endcase
      end
      default: op.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/macc_arith.sv
module macc_arith
  import macc_pkg::*;
(
  input  mac_op_t         op,
  input  logic [HALF-1:0] opa,
  input  logic [HALF-1:0] opb,
  input  logic [XLEN-1:0] hi,
  input  logic [XLEN-1:0] lo,
  output logic [XLEN-1:0] nxt_hi,
  output logic [XLEN-1:0] nxt_lo,
  output logic [XLEN-1:0] nxt_dest
);
  logic [XLEN-1:0] prod, base, raw;
  logic [XLEN:0]   wide_b, wide_p, wide_sum;
  logic            is_dword;

  assign is_dword = (op.kind == OPK_DADD);
  assign prod     = mac_product(opa, opb, op.uns);
  assign base     = is_dword ? lo : {hi[HALF-1:0], lo[HALF-1:0]};
  assign wide_b   = op.uns ? {1'b0, base} : {base[XLEN-1], base};
  assign wide_p   = op.uns ? {1'b0, prod} : {prod[XLEN-1], prod};
  assign wide_sum = wide_b + wide_p;

  always_comb begin
    unique case (op.kind)
      OPK_CLEAR: raw = prod;
      OPK_NEG:   raw = {XLEN{1'b0}} - prod;
      OPK_SUB:   raw = base - prod;
      default: begin
        if (!op.sat)     raw = wide_sum[XLEN-1:0];
        else if (op.uns) raw = clamp_unsigned(wide_sum);
        else             raw = clamp_signed(wide_sum);
      end
    endcase
  end

  always_comb begin
    if (is_dword) begin
      nxt_hi   = hi;
      nxt_lo   = raw;
      nxt_dest = raw;
    end else begin
      nxt_hi   = {hi[XLEN-1:HALF], raw[XLEN-1:HALF]};
      nxt_lo   = {lo[XLEN-1:HALF], raw[HALF-1:0]};
      nxt_dest = op.hi_sel ? sext_half(raw[XLEN-1:HALF]) : sext_half(raw[HALF-1:0]);
    end
  end
endmodule

// File: rtl/macc_ctrl.sv
module macc_ctrl #(
  parameter int LATENCY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic accept,
  output logic commit
);
  localparam int CW = $clog2(LATENCY + 1);
  logic [CW-1:0] cnt;

  assign accept = start && !busy;
  assign commit = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= CW'(LATENCY - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/macc_hilo_unit.sv
module macc_hilo_unit
  import macc_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [SA_W-1:0] sa_code,
  input  logic [FN_W-1:0] fn_code,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            busy,
  output logic            done,
  output logic            bad_op,
  output logic [XLEN-1:0] dest_out,
  output logic [XLEN-1:0] hi_out,
  output logic [XLEN-1:0] lo_out
);
  mac_op_t         dec_op, op_q;
  logic [HALF-1:0] a_q, b_q;
  logic            accept, commit;
  logic [XLEN-1:0] nxt_hi, nxt_lo, nxt_dest;
  logic [XLEN-1:0] hi_q, lo_q, dest_q;
  logic            done_q, bad_q;

  // Named views of the operation being completed, for the checker.
  logic op_dword, op_hi_sel;
  assign op_dword  = (op_q.kind == OPK_DADD);
  assign op_hi_sel = op_q.hi_sel;

  macc_decode u_dec (
    .sa_code (sa_code),
    .fn_code (fn_code),
    .op      (dec_op)
  );

  macc_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .accept (accept),
    .commit (commit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else if (accept) begin
      op_q <= dec_op;
      a_q  <= src_a[HALF-1:0];
      b_q  <= src_b[HALF-1:0];
    end
  end

  macc_arith u_arith (
    .op       (op_q),
    .opa      (a_q),
    .opb      (b_q),
    .hi       (hi_q),
    .lo       (lo_q),
    .nxt_hi   (nxt_hi),
    .nxt_lo   (nxt_lo),
    .nxt_dest (nxt_dest)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      dest_q <= '0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      done_q <= commit;
      bad_q  <= commit && !op_q.legal;
      if (commit) begin
        if (op_q.legal) begin
          hi_q   <= nxt_hi;
          lo_q   <= nxt_lo;
          dest_q <= nxt_dest;
        end else begin
          dest_q <= '0;
        end
      end
    end
  end

  assign done     = done_q;
  assign bad_op   = bad_q;
  assign dest_out = dest_q;
  assign hi_out   = hi_q;
  assign lo_out   = lo_q;
endmodule

// File: rtl/macc_hilo_chk.sv
module macc_hilo_chk #(
  parameter int W = 64,
  parameter int H = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         bad_op,
  input logic         op_dword,
  input logic         op_hi_sel,
  input logic [W-1:0] dest_out,
  input logic [W-1:0] hi_out,
  input logic [W-1:0] lo_out
);
  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  p_hilo_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi_out) && $stable(lo_out)));

  p_bad_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> (done && $stable(hi_out) && $stable(lo_out) && dest_out == '0));

  p_upper_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_dword) |-> (hi_out[W-1:H] == $past(hi_out[W-1:H]) &&
                             lo_out[W-1:H] == $past(lo_out[W-1:H])));

  p_dword_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_dword && !bad_op) |-> ($stable(hi_out) && dest_out == lo_out));

  p_low_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bad_op && !op_dword && !op_hi_sel) |->
      (dest_out == {{H{lo_out[H-1]}}, lo_out[H-1:0]}));

  p_high_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bad_op && !op_dword && op_hi_sel) |->
      (dest_out == {{H{hi_out[H-1]}}, hi_out[H-1:0]}));
endmodule

bind macc_hilo_unit macc_hilo_chk #(.W(macc_pkg::XLEN), .H(macc_pkg::HALF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .bad_op    (bad_op),
  .op_dword  (op_dword),
  .op_hi_sel (op_hi_sel),
  .dest_out  (dest_out),
  .hi_out    (hi_out),
  .lo_out    (lo_out)
);

// File: tb/macc_hilo_unit_bench.sv
module macc_hilo_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  sa_code = '0;
  logic [5:0]  fn_code = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        busy, done, bad_op;
  logic [63:0] dest_out, hi_out, lo_out;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] m_hi = '0, m_lo = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  macc_hilo_unit #(.LATENCY(LAT)) u_macc_hilo_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .sa_code(sa_code), .fn_code(fn_code),
    .src_a(src_a), .src_b(src_b), .busy(busy), .done(done), .bad_op(bad_op),
    .dest_out(dest_out), .hi_out(hi_out), .lo_out(lo_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements; updates m_hi/m_lo.
  task automatic model(input logic [4:0] sa, input logic [5:0] fn,
                       input logic [63:0] a, input logic [63:0] b,
                       output bit legal, output logic [63:0] edest, output string tag);
    logic [5:0] cfg;  // {kind[2:0], uns, sat, hs}
    logic signed [127:0] pa, pb, p, base, r;
    logic [63:0] acc, res;
    legal = 1'b1;
    case ({fn, sa})
      {6'b101000, 5'b00100}: cfg = 6'b000_000;
      {6'b101000, 5'b00101}: cfg = 6'b000_100;
      {6'b101000, 5'b01100}: cfg = 6'b000_001;
      {6'b101000, 5'b01101}: cfg = 6'b000_101;
      {6'b101000, 5'b00010}: cfg = 6'b010_000;
      {6'b101000, 5'b00011}: cfg = 6'b010_100;
      {6'b101000, 5'b01010}: cfg = 6'b010_001;
      {6'b101000, 5'b01011}: cfg = 6'b010_101;
      {6'b101000, 5'b10000}: cfg = 6'b010_010;
      {6'b101000, 5'b10001}: cfg = 6'b010_110;
      {6'b101000, 5'b11000}: cfg = 6'b010_011;
      {6'b101000, 5'b11001}: cfg = 6'b010_111;
      {6'b101001, 5'b00000}: cfg = 6'b100_000;
      {6'b101001, 5'b00001}: cfg = 6'b100_100;
      {6'b101001, 5'b10000}: cfg = 6'b100_010;
      {6'b101001, 5'b10001}: cfg = 6'b100_110;
      {6'b011000, 5'b00011}: cfg = 6'b001_000;
      {6'b011000, 5'b01011}: cfg = 6'b001_001;
      {6'b011000, 5'b01111}: cfg = 6'b011_001;
      {6'b011001, 5'b00011}: cfg = 6'b001_100;
      {6'b011001, 5'b01011}: cfg = 6'b001_101;
      {6'b011001, 5'b01111}: cfg = 6'b011_101;
      {6'b011001, 5'b00111}: cfg = 6'b011_100;
      default: begin cfg = '0; legal = 1'b0; end
    endcase
    if (!legal) begin
      edest = '0;
      tag = "R11";
      return;
    end
    pa = cfg[2] ? $signed({96'b0, a[31:0]}) : $signed({{96{a[31]}}, a[31:0]});
    pb = cfg[2] ? $signed({96'b0, b[31:0]}) : $signed({{96{b[31]}}, b[31:0]});
    p  = pa * pb;
    acc = (cfg[5:3] == 3'd4) ? m_lo : {m_hi[31:0], m_lo[31:0]};
    base = cfg[2] ? $signed({64'b0, acc}) : $signed({{64{acc[63]}}, acc});
    case (cfg[5:3])
      3'd0: r = p;
      3'd1: r = -p;
      3'd3: r = base - p;
      default: r = base + p;
    endcase
    res = r[63:0];
    if (cfg[1]) begin
      if (cfg[2]) begin
        if (r > 128'sh7FFF_FFFF) res = '1;
      end else begin
        if (r > 128'sh7FFF_FFFF) res = 64'h0000_0000_7FFF_FFFF;
        else if (r < -128'sh8000_0000) res = 64'hFFFF_FFFF_8000_0000;
      end
    end
    if (cfg[5:3] == 3'd4) begin
      m_lo = res;
      edest = res;
      tag = "R8";
    end else begin
      m_hi[31:0] = res[63:32];
      m_lo[31:0] = res[31:0];
      edest = cfg[0] ? {{32{res[63]}}, res[63:32]} : {{32{res[31]}}, res[31:0]};
      tag = (cfg[5:3] <= 3'd1) ? "R5" : "R6";
    end
    if (cfg[1]) tag = cfg[2] ? "R10" : "R9";
  endtask

  // Issue one operation at a falling edge and check every output at its due point.
  task automatic run_op(input logic [4:0] sa, input logic [5:0] fn,
                        input logic [63:0] a, input logic [63:0] b,
                        output logic [63:0] got_dest);
    bit legal;
    logic [63:0] edest, pre_hi, pre_lo;
    string tag;
    int cnt;
    pre_hi = m_hi;
    pre_lo = m_lo;
    model(sa, fn, a, b, legal, edest, tag);
    sa_code = sa; fn_code = fn; src_a = a; src_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < LAT + 8) begin
      // R12: HI/LO hold while the operation is in flight
      chk(hi_out == pre_hi && lo_out == pre_lo, "R12 hold", hi_out, pre_hi);
      @(negedge clk);
      cnt++;
    end
    chk(cnt == LAT + 1, "R2 latency", 64'(cnt), 64'(LAT + 1));
    chk(bad_op == !legal, "R11 bad_op", 64'(bad_op), 64'(!legal));
    chk(dest_out == edest, {"R7 dest ", tag}, dest_out, edest);
    chk(hi_out == m_hi, {"R3 hi ", tag}, hi_out, m_hi);
    chk(lo_out == m_lo, {"R3 lo ", tag}, lo_out, m_lo);
    got_dest = dest_out;
    @(negedge clk);
    chk(!done, "R2 single pulse", 64'(done), 64'd0);
  endtask

  function automatic logic [63:0] opval(input int i);
    logic [31:0] lw;
    case (i)
      0: lw = 32'h0000_0000;
      1: lw = 32'h0000_0001;
      2: lw = 32'hFFFF_FFFF;
      3: lw = 32'h7FFF_FFFF;
      4: lw = 32'h8000_0000;
      default: lw = 32'h0001_2345;
    endcase
    return {32'hA5C3_0000 ^ 32'(i * 32'h1111), lw};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [5:0] fns [6];
    fns = '{6'b101000, 6'b101001, 6'b011000, 6'b011001, 6'b000000, 6'b111111};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hi_out == 0 && lo_out == 0 && dest_out == 0, "R1 regs", hi_out | lo_out | dest_out, 64'd0);
    chk(!busy && !done && !bad_op, "R1 flags", {61'd0, busy, done, bad_op}, 64'd0);

    // R4: upper source bits ignored, signed extension of low words
    run_op(5'b00100, 6'b101000, 64'hDEAD_BEEF_FFFF_FFFE, 64'h1234_5678_0000_0003, d);
    chk(d == 64'hFFFF_FFFF_FFFF_FFFA, "R4 signed low product", d, 64'hFFFF_FFFF_FFFF_FFFA);
    run_op(5'b01101, 6'b101000, 64'h0000_0001_FFFF_FFFF, 64'hFFFF_0000_0000_0002, d);
    chk(d == 64'h0000_0000_0000_0001, "R4 unsigned high product", d, 64'd1);

    // R3: doubleword sets LO upper word, later single-word ops keep it
    run_op(5'b00000, 6'b101001, 64'h0000_0000_4000_0000, 64'h0000_0000_0000_0010, d);
    run_op(5'b00100, 6'b101000, 64'd7, 64'd9, d);
    chk(lo_out[63:32] == 32'h0000_0004, "R3 LO upper kept", {32'd0, lo_out[63:32]}, 64'd4);

    // R9: signed clamp at both ends
    run_op(5'b00100, 6'b101000, 64'h7FFF_FFFF, 64'd1, d);
    run_op(5'b10000, 6'b101000, 64'd1, 64'd1, d);
    chk(d == 64'h0000_0000_7FFF_FFFF, "R9 clamp high", d, 64'h7FFF_FFFF);
    run_op(5'b00100, 6'b101000, 64'h8000_0000, 64'd1, d);
    run_op(5'b10000, 6'b101000, 64'hFFFF_FFFF, 64'd1, d);
    chk(d == 64'hFFFF_FFFF_8000_0000, "R9 clamp low", d, 64'hFFFF_FFFF_8000_0000);

    // R10: unsigned saturation to all ones
    run_op(5'b00101, 6'b101000, 64'h7FFF_FFFF, 64'd1, d);
    run_op(5'b10001, 6'b101000, 64'd1, 64'd1, d);
    chk(d == 64'hFFFF_FFFF_FFFF_FFFF, "R10 saturate", d, '1);

    // R2: start while busy is ignored
    begin
      logic [63:0] exp_d;
      bit lg;
      string tg;
      model(5'b00100, 6'b101000, 64'd5, 64'd6, lg, exp_d, tg);
      sa_code = 5'b00100; fn_code = 6'b101000; src_a = 64'd5; src_b = 64'd6; start = 1'b1;
      @(negedge clk);
      sa_code = 5'b01100; src_a = 64'd100; src_b = 64'd100;
      @(negedge clk);
      start = 1'b0;
      repeat (LAT - 1) @(negedge clk);
      chk(done == 1'b1, "R2 first done", 64'(done), 64'd1);
      chk(dest_out == exp_d, "R2 busy start ignored", dest_out, exp_d);
      for (int k = 0; k < LAT + 3; k++) begin
        @(negedge clk);
        chk(!done && !busy, "R2 no second op", {62'd0, done, busy}, 64'd0);
      end
      chk(lo_out == m_lo && hi_out == m_hi, "R2 state after ignored start", lo_out, m_lo);
    end

    // Decode and arithmetic sweep: all variant codes, several function codes, operand pairs
    for (int f = 0; f < 6; f++)
      for (int s = 0; s < 32; s++)
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            run_op(5'(s), fns[f], opval(i), opval(j), d);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule